// File: doc/BRIEF.md
# L2 Dual Hash Index Generator

This block turns a MAC address and a 12-bit VLAN or forwarding ID into two bucket indices for a 16384-entry, 4-way L2 forwarding table. The table is treated as two halves of 2048 buckets each. The block forms a 60-bit key with the ID on top and the MAC below it. It then computes two 11-bit XOR folds of that key. One fold is a plain fold. The other rotates two of its chunks before folding.

Two configuration bits pick one fold for each half, independently of each other. The lower index addresses buckets 0 to 2047. The upper index is offset by 2048, so it always lands in the upper half. A lookup engine presents a key with a valid strobe. One clock later it receives both indices, which it then uses to probe the two candidate buckets. The indices are also supplied packed into one 32-bit word.

Top module: `l2_dual_hash_idx`

## Requirements
- R1: The key is 60 bits wide. The ID occupies key bits 59:48 and the MAC occupies key bits 47:0, so a change in any ID bit or MAC bit alters the fold it reaches.
- R2: The plain fold XORs together five 11-bit slices of the key, taken at bits 54:44, 43:33, 32:22, 21:11 and 10:0, and also key bits 59:55 zero-extended to 11 bits.
- R3: The rotating fold uses the same six terms with two changes. Slice 21:11 is rotated right by 5 inside its 11 bits, so its low 5 bits move to the top. Slice 43:33 is rotated right by 6 inside its 11 bits.
- R4: alg_sel[0] set gives the lower index the rotating fold; clear gives it the plain fold. The lower index is always in the range 0 to 2047.
- R5: alg_sel[1] chooses the fold for the upper index in the same way. The upper index is that fold plus 2048, so it is always in the range 2048 to 4095. When both select bits are equal, the two indices differ by exactly 2048.
- R6: bucket_word carries the lower index in bits 15:0 and the upper index in bits 31:16, with bits 15:12 and 31:28 zero.
- R7: Results appear exactly one clock after the key is presented with in_valid high. out_valid is high in exactly those cycles, and back-to-back keys yield back-to-back results.
- R8: While in_valid is low, changes on mac, vid and alg_sel are ignored, and all index outputs hold their last values.
- R9: After reset, out_valid is low and all index outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Key strobe |
| mac | input | 48 | MAC address, key bits 47:0 |
| vid | input | 12 | VLAN or forwarding ID, key bits 59:48 |
| alg_sel | input | 2 | Bit 0: fold for lower half; bit 1: fold for upper half (1 = rotating) |
| out_valid | output | 1 | Indices valid |
| bucket_lo | output | 12 | Bucket index in lower half |
| bucket_hi | output | 12 | Bucket index in upper half |
| bucket_word | output | 32 | Both indices packed {hi, lo} in 16-bit fields |

## Verification
A misplaced slice boundary or a wrong rotation amount shows up as a wrong index on the first result whose key has a bit set in the affected slice. The walking-bit sweep over all 60 key bits, under every select setting, therefore exposes such a fault within one cycle of that key. A broken select mux shows up in the same way. A broken offset flips bit 11 of the upper index immediately.

A stuck or mis-enabled result register breaks the one-cycle timing on the very next strobe. It also makes the outputs drift during idle cycles, where the scoreboard compares them against the last delivered result on every clock.

// File: rtl/l2h_pkg.sv
package l2h_pkg;

  typedef enum logic {
    FOLD_PLAIN = 1'b0,
    FOLD_ROT   = 1'b1
  } fold_kind_e;

  function automatic int lane_count(input int total_w, input int lane_w);
    return (total_w + lane_w - 1) / lane_w;
  endfunction

  function automatic int rot_for_lane(input fold_kind_e kind, input int lane,
                                      input int lane_a, input int rot_a,
                                      input int lane_b, input int rot_b);
    if (kind == FOLD_PLAIN) return 0;
    if (lane == lane_a) return rot_a;
    if (lane == lane_b) return rot_b;
    return 0;
  endfunction

endpackage

// File: rtl/l2h_rst_sync.sv
module l2h_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/l2h_fold.sv
module l2h_fold
  import l2h_pkg::*;
#(
  parameter int         KEY_W  = 60,
  parameter int         LANE_W = 11,
  parameter fold_kind_e KIND   = FOLD_PLAIN,
  parameter int         LANE_A = 1,
  parameter int         ROT_A  = 5,
  parameter int         LANE_B = 3,
  parameter int         ROT_B  = 6
) (
  input  logic [KEY_W-1:0]  key,
  output logic [LANE_W-1:0] folded
);
  localparam int NLANES = lane_count(KEY_W, LANE_W);
  localparam int PAD_W  = NLANES * LANE_W;

  logic [PAD_W-1:0]  key_pad;
  logic [LANE_W-1:0] lane_v [NLANES];
  logic [LANE_W-1:0] acc;

  assign key_pad = PAD_W'(key);

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    localparam int R = rot_for_lane(KIND, i, LANE_A, ROT_A, LANE_B, ROT_B);
    logic [LANE_W-1:0] raw;
    assign raw = key_pad[i*LANE_W +: LANE_W];
    if (R == 0) begin : g_straight
      assign lane_v[i] = raw;
    end else begin : g_rotate
      assign lane_v[i] = (raw >> R) | (raw << (LANE_W - R));
    end
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NLANES; i++) acc = acc ^ lane_v[i];
  end

  assign folded = acc;
endmodule

// File: rtl/l2h_half_sel.sv
module l2h_half_sel #(
  parameter int LANE_W = 11,
  parameter int IDX_W  = 12,
  parameter int OFFSET = 0
) (
  input  logic              use_rot,
  input  logic [LANE_W-1:0] fold_plain,
  input  logic [LANE_W-1:0] fold_rot,
  output logic [IDX_W-1:0]  idx
);
  logic [LANE_W-1:0] pick;

  always_comb begin
    pick = use_rot ? fold_rot : fold_plain;
    idx  = IDX_W'(pick) + IDX_W'(OFFSET);
  end
endmodule

// File: rtl/l2_dual_hash_idx.sv
module l2_dual_hash_idx
  import l2h_pkg::*;
#(
  parameter int MAC_W      = 48,
  parameter int VID_W      = 12,
  parameter int LANE_W     = 11,
  parameter int TBL_SLOTS  = 16384,
  parameter int WAYS       = 4,
  parameter int HALVES     = 2,
  parameter int FIELD_W    = 16,
  parameter int ROT_LANE_A = 1,
  parameter int ROT_AMT_A  = 5,
  parameter int ROT_LANE_B = 3,
  parameter int ROT_AMT_B  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [MAC_W-1:0]        mac,
  input  logic [VID_W-1:0]        vid,
  input  logic [HALVES-1:0]       alg_sel,
  output logic                    out_valid,
  output logic [$clog2(TBL_SLOTS/WAYS)-1:0] bucket_lo,
  output logic [$clog2(TBL_SLOTS/WAYS)-1:0] bucket_hi,
  output logic [HALVES*FIELD_W-1:0] bucket_word
);
  localparam int KEY_W       = VID_W + MAC_W;
  localparam int BUCKETS     = TBL_SLOTS / WAYS;
  localparam int IDX_W       = $clog2(BUCKETS);
  localparam int HALF_SPAN   = BUCKETS / HALVES;

  logic              rst_sync_n;
  logic [KEY_W-1:0]  key;
  logic [LANE_W-1:0] fold_p;
  logic [LANE_W-1:0] fold_r;
  logic [IDX_W-1:0]  idx_new [HALVES];
  logic [IDX_W-1:0]  idx_nxt [HALVES];
  logic [IDX_W-1:0]  idx_q   [HALVES];
  logic              vld_nxt;
  logic              vld_q;

  l2h_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign key = {vid, mac};

  l2h_fold #(
    .KEY_W(KEY_W), .LANE_W(LANE_W), .KIND(FOLD_PLAIN),
    .LANE_A(ROT_LANE_A), .ROT_A(ROT_AMT_A), .LANE_B(ROT_LANE_B), .ROT_B(ROT_AMT_B)
  ) u_fold_plain (
    .key(key), .folded(fold_p)
  );

  l2h_fold #(
    .KEY_W(KEY_W), .LANE_W(LANE_W), .KIND(FOLD_ROT),
    .LANE_A(ROT_LANE_A), .ROT_A(ROT_AMT_A), .LANE_B(ROT_LANE_B), .ROT_B(ROT_AMT_B)
  ) u_fold_rot (
    .key(key), .folded(fold_r)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    l2h_half_sel #(
      .LANE_W(LANE_W), .IDX_W(IDX_W), .OFFSET(h * HALF_SPAN)
    ) u_sel (
      .use_rot(alg_sel[h]), .fold_plain(fold_p), .fold_rot(fold_r),
      .idx(idx_new[h])
    );
  end

  // next-state: capture only on a key strobe
  always_comb begin
    vld_nxt = in_valid;
    for (int h = 0; h < HALVES; h++)
      idx_nxt[h] = in_valid ? idx_new[h] : idx_q[h];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      for (int h = 0; h < HALVES; h++) idx_q[h] <= '0;
    end else begin
      vld_q <= vld_nxt;
      for (int h = 0; h < HALVES; h++) idx_q[h] <= idx_nxt[h];
    end
  end

  assign out_valid = vld_q;
  assign bucket_lo = idx_q[0];
  assign bucket_hi = idx_q[HALVES-1];

  for (genvar h = 0; h < HALVES; h++) begin : g_pack
    assign bucket_word[h*FIELD_W +: FIELD_W] = FIELD_W'(idx_q[h]);
  end

  // R7: result strobe trails the key strobe by exactly one clock
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) |-> (out_valid == $past(in_valid)));

  // R8: no strobe, no change
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && !$past(in_valid)) |-> ($stable(bucket_lo) && $stable(bucket_hi)));

  // R4: lower index stays in the lower half
  a_r4_lo_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (int'(bucket_lo) < HALF_SPAN));

  // R5: upper index stays in the upper half
  a_r5_hi_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (int'(bucket_hi) >= HALF_SPAN));

  // R5: equal selects give indices a half-span apart
  a_r5_same_fold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(in_valid) && ($past(alg_sel[0]) == $past(alg_sel[HALVES-1])))
    |-> ((int'(bucket_hi) - int'(bucket_lo)) == HALF_SPAN));
endmodule

// File: tb/l2_dual_hash_idx_test.sv
`timescale 1ns/1ps
module l2_dual_hash_idx_test;

  typedef struct {
    logic [47:0] mac;
    logic [11:0] vid;
    logic [1:0]  cfg;
    int          due;
    string       note;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [47:0] mac;
  logic [11:0] vid;
  logic [1:0]  alg_sel;
  logic        out_valid;
  logic [11:0] bucket_lo, bucket_hi;
  logic [31:0] bucket_word;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  item_t sb[$];
  logic [11:0] last_lo, last_hi;
  bit    have_last = 0;
  bit    done = 0;

  always #4 clk = ~clk;

  l2_dual_hash_idx uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mac(mac), .vid(vid),
    .alg_sel(alg_sel), .out_valid(out_valid), .bucket_lo(bucket_lo),
    .bucket_hi(bucket_hi), .bucket_word(bucket_word)
  );

  function automatic logic [10:0] ref_fold(logic [59:0] s, bit rot);
    logic [10:0] a, b;
    a = s[21:11];
    b = s[43:33];
    if (rot) begin
      a = {a[4:0], a[10:5]};
      b = {b[5:0], b[10:6]};
    end
    return {6'b0, s[59:55]} ^ s[54:44] ^ b ^ s[32:22] ^ a ^ s[10:0];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h expected %h (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  task automatic send(logic [47:0] m, logic [11:0] v, logic [1:0] c, string note);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; mac = m; vid = v; alg_sel = c;
    it.mac = m; it.vid = v; it.cfg = c; it.due = cyc + 1; it.note = note;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      mac = {$urandom, $urandom} ;
      vid = 12'($urandom);
      alg_sel = 2'($urandom);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #2;
      if (sb.size() > 0 && sb[0].due == cyc) begin
        item_t it;
        logic [59:0] s;
        logic [11:0] elo, ehi;
        it = sb.pop_front();
        s = {it.vid, it.mac};
        elo = {1'b0, ref_fold(s, it.cfg[0])};
        ehi = {1'b1, ref_fold(s, it.cfg[1])};
        check(out_valid === 1'b1, "R7 out_valid on result cycle", 32'(out_valid), 32'd1);
        check(bucket_lo === elo, $sformatf("R4 lower index %s %s", it.cfg[0] ? "R3" : "R2", it.note),
              32'(bucket_lo), 32'(elo));
        check(bucket_hi === ehi, $sformatf("R5 upper index %s %s", it.cfg[1] ? "R3" : "R2", it.note),
              32'(bucket_hi), 32'(ehi));
        check(bucket_word === {4'b0, ehi, 4'b0, elo}, "R6 packed word",
              bucket_word, {4'b0, ehi, 4'b0, elo});
        last_lo = elo; last_hi = ehi; have_last = 1;
      end else begin
        check(out_valid === 1'b0, "R7 out_valid without key", 32'(out_valid), 32'd0);
        if (have_last && rst_n) begin
          check(bucket_lo === last_lo && bucket_hi === last_hi, "R8 hold while idle",
                {4'b0, bucket_hi, 4'b0, bucket_lo}, {4'b0, last_hi, 4'b0, last_lo});
        end
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; mac = '0; vid = '0; alg_sel = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(out_valid === 1'b0, "R9 out_valid in reset", 32'(out_valid), 0);
    check(bucket_word === 32'd0 && bucket_lo === 12'd0 && bucket_hi === 12'd0,
          "R9 indices in reset", bucket_word, 0);
    rst_n = 1'b1;
    idle(4);

    // corner keys under all selects
    for (int c = 0; c < 4; c++) send(48'h0, 12'h0, 2'(c), "zero key");
    for (int c = 0; c < 4; c++) send('1, 12'hFFF, 2'(c), "ones key");
    for (int c = 0; c < 4; c++) send(48'h0, 12'hF80, 2'(c), "R1 top ID bits");
    idle(3);

    // walking bit across the whole key, every select combination
    for (int b = 0; b < 60; b++) begin
      for (int c = 0; c < 4; c++) begin
        logic [59:0] s;
        s = 60'd1 << b;
        send(s[47:0], s[59:48], 2'(c), (b >= 48) ? "R1 ID bit" : "R1 MAC bit");
      end
    end
    idle(5);

    // random keys with random gaps
    for (int i = 0; i < 300; i++) begin
      send({$urandom, $urandom}, 12'($urandom), 2'($urandom), "random");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(6);

    check(sb.size() == 0, "R7 all results delivered", sb.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule